// File: doc/BRIEF.md
# Test Register Channel Sequencer

This block is the diagnostic test register that a host processor uses to inspect the data paths of a video output stage. A write to the register loads a 3-bit channel selector. A read returns one byte from the selected channel. The channels are the three palette color values that enter the converters, a fixed identification code, the three ones-accumulation results and the analog test status. All of this channel data arrives on input buses. The palette, the accumulators and the analog test are produced elsewhere.

Reads of the palette color channels step the selector automatically, so the host can fetch red, green and blue with one write and a run of reads. A read of the identification channel also steps the selector, into red. From then on the selector stays in the color loop until the host writes the identification code again. Reads of the accumulation channels and the analog channel leave the selector where it is.

The selector is a state machine with eight named states, one per code: `S_PAL_R` (000), `S_PAL_G` (001), `S_PAL_B` (010), `S_ID` (011), `S_ACC_R` (100), `S_ACC_G` (101), `S_ACC_B` (110), `S_ANALOG` (111). A write moves any state to the state whose code the host wrote. A read moves `S_PAL_R`→`S_PAL_G`, `S_PAL_G`→`S_PAL_B`, `S_PAL_B`→`S_PAL_R` and `S_ID`→`S_PAL_R`. A read is a self-loop for `S_ACC_R`, `S_ACC_G`, `S_ACC_B` and `S_ANALOG`. With no strobe active, every state holds.

Top module: `tst_chan_seq`

## Requirements
- R1: After reset the selector is at code 000 (red palette value), and `rd_data` is 0.
- R2: A read counts once, on the first clock at which `rd_en` is high. At that clock edge, `rd_data` is loaded with the byte of the current channel, so the value can be seen one clock after that first clock. Codes 000, 001 and 010 select `pal_r`, `pal_g` and `pal_b`. Code 011 selects the ID. Codes 100, 101 and 110 select `acc_r`, `acc_g` and `acc_b`. Code 111 selects `ana_stat`.
- R3: A read of a palette color channel moves the selector to the next color in the order red, green, blue, and blue wraps to red. Writing 001 and then reading three times returns green, blue, red.
- R4: A read of the ID channel returns the constant `ID_CODE` (default 0x76) and moves the selector to red. Writing 011 and then reading six times returns ID, red, green, blue, red, green.
- R5: Once the selector has left the ID channel, it returns to the ID channel only when 011 is written.
- R6: Reads of codes 100, 101, 110 and 111 leave the selector unchanged.
- R7: A read strobe that stays high for several clocks counts as one read and advances the selector only once.
- R8: A write sets the selector from `wr_data[2:0]`. The upper bits of `wr_data` are ignored. A write in the same clock as a read start takes precedence: the read is discarded, and `rd_data` does not change.
- R9: `rd_data` holds its value between reads, even when the channel inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW | Host write data; bits [2:0] are the channel code |
| rd_en | input | 1 | Host read strobe; its first high clock counts as one read |
| rd_data | output | DW | Byte from the last read |
| pal_r | input | DW | Red palette value entering the converter |
| pal_g | input | DW | Green palette value |
| pal_b | input | DW | Blue palette value |
| acc_r | input | DW | Red ones-accumulation result |
| acc_g | input | DW | Green ones-accumulation result |
| acc_b | input | DW | Blue ones-accumulation result |
| ana_stat | input | DW | Analog test status |

## Verification
The assertions check the following on every cycle:
- each color step and the blue-to-red wrap;
- the exit from the ID state into red;
- that no state other than ID steps into ID without a write;
- the self-loops of the accumulation and analog states;
- that a held strobe yields a single read event;
- that a write loads the selector;
- that the ID byte is returned;
- that `rd_data` stays stable while no read occurs.

Some behaviour only the bench's scenarios can show:
- the full read sequences after writes of 001 and 011;
- the mapping from each code to the correct input bus;
- that the upper bits of the write data are ignored;
- a write and a read in the same clock;
- the reset value seen at the port.

// File: rtl/tst_chan_pkg.sv
package tst_chan_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        S_PAL_R  = 3'b000,
        S_PAL_G  = 3'b001,
        S_PAL_B  = 3'b010,
        S_ID     = 3'b011,
        S_ACC_R  = 3'b100,
        S_ACC_G  = 3'b101,
        S_ACC_B  = 3'b110,
        S_ANALOG = 3'b111
    } chan_e;

    function automatic logic is_color(chan_e s);
        return (s == S_PAL_R) || (s == S_PAL_G) || (s == S_PAL_B);
    endfunction

    function automatic logic is_parked(chan_e s);
        return (s == S_ACC_R) || (s == S_ACC_G) || (s == S_ACC_B) || (s == S_ANALOG);
    endfunction

endpackage

// File: rtl/tst_strobe_edge.sv
module tst_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
        end
    end

    assign pulse = strobe & ~strobe_q;

    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R7

    AST_HELD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> !pulse); // R7

endmodule

// File: rtl/tst_chan_fsm.sv
module tst_chan_fsm
    import tst_chan_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_evt,
    output chan_e         state
);

    chan_e state_nx;
    logic  unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DW-1:SEL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_PAL_R;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (wr_en) begin
            state_nx = chan_e'(wr_data[SEL_W-1:0]);
        end else if (rd_evt) begin
            unique case (state)
                S_PAL_R:  state_nx = S_PAL_G;
                S_PAL_G:  state_nx = S_PAL_B;
                S_PAL_B:  state_nx = S_PAL_R;
                S_ID:     state_nx = S_PAL_R;
                S_ACC_R:  state_nx = S_ACC_R;
                S_ACC_G:  state_nx = S_ACC_G;
                S_ACC_B:  state_nx = S_ACC_B;
                S_ANALOG: state_nx = S_ANALOG;
            endcase
        end
    end

    AST_RED_TO_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !wr_en && state == S_PAL_R) |=> state == S_PAL_G); // R3

    AST_GREEN_TO_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !wr_en && state == S_PAL_G) |=> state == S_PAL_B); // R3

    AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !wr_en && state == S_PAL_B) |=> state == S_PAL_R); // R3

    AST_ID_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !wr_en && state == S_ID) |=> state == S_PAL_R); // R4

    AST_NO_ID_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_ID && !wr_en) |=> state != S_ID); // R5

    AST_PARKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_parked(state) && !wr_en) |=> $stable(state)); // R6

    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state == $past(wr_data[SEL_W-1:0])); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_evt) |=> $stable(state)); // R2

endmodule

// File: rtl/tst_read_mux.sv
module tst_read_mux
    import tst_chan_pkg::*;
#(
    parameter int          DW      = 8,
    parameter logic [DW-1:0] ID_CODE = 8'h76
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  chan_e         sel,
    input  logic [DW-1:0] pal_r,
    input  logic [DW-1:0] pal_g,
    input  logic [DW-1:0] pal_b,
    input  logic [DW-1:0] acc_r,
    input  logic [DW-1:0] acc_g,
    input  logic [DW-1:0] acc_b,
    input  logic [DW-1:0] ana_stat,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] pick;

    always_comb begin
        unique case (sel)
            S_PAL_R:  pick = pal_r;
            S_PAL_G:  pick = pal_g;
            S_PAL_B:  pick = pal_b;
            S_ID:     pick = ID_CODE;
            S_ACC_R:  pick = acc_r;
            S_ACC_G:  pick = acc_g;
            S_ACC_B:  pick = acc_b;
            S_ANALOG: pick = ana_stat;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (load) begin
            rd_data <= pick;
        end
    end

    AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel == S_ID) |=> rd_data == ID_CODE); // R4

    AST_RED_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel == S_PAL_R) |=> rd_data == $past(pal_r)); // R2

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rd_data)); // R9

endmodule

// File: rtl/tst_chan_seq.sv
module tst_chan_seq
    import tst_chan_pkg::*;
#(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] ID_CODE = 8'h76
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] pal_r,
    input  logic [DW-1:0] pal_g,
    input  logic [DW-1:0] pal_b,
    input  logic [DW-1:0] acc_r,
    input  logic [DW-1:0] acc_g,
    input  logic [DW-1:0] acc_b,
    input  logic [DW-1:0] ana_stat
);

    logic  rd_pulse;
    logic  rd_evt;
    chan_e sel;

    tst_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_en),
        .pulse  (rd_pulse)
    );

    assign rd_evt = rd_pulse & ~wr_en;

    tst_chan_fsm #(.DW(DW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_evt  (rd_evt),
        .state   (sel)
    );

    tst_read_mux #(.DW(DW), .ID_CODE(ID_CODE)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_evt),
        .sel      (sel),
        .pal_r    (pal_r),
        .pal_g    (pal_g),
        .pal_b    (pal_b),
        .acc_r    (acc_r),
        .acc_g    (acc_g),
        .acc_b    (acc_b),
        .ana_stat (ana_stat),
        .rd_data  (rd_data)
    );

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_pulse) |=> $stable(rd_data)); // R8

endmodule

// File: tb/sim_tst_chan_seq.sv
module sim_tst_chan_seq;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] pal_r = 8'h11, pal_g = 8'h22, pal_b = 8'h33;
    logic [DW-1:0] acc_r = 8'h44, acc_g = 8'h55, acc_b = 8'h66;
    logic [DW-1:0] ana_stat = 8'h7A;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    event          rd_go;

    always #2 clk = ~clk;

    tst_chan_seq #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .pal_r(pal_r), .pal_g(pal_g), .pal_b(pal_b),
        .acc_r(acc_r), .acc_g(acc_g), .acc_b(acc_b), .ana_stat(ana_stat)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(logic [DW-1:0] exp, string tag, int hold = 1);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1;
        -> rd_go;
        repeat (hold) @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(rd_go);
            @(posedge clk);
            @(negedge clk);
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rd_data", rd_data, 8'h00);
        do_read(8'h11, "R1 reset selector red");
        do_read(8'h22, "R3 step after reset");

        do_write(8'h01);
        do_read(8'h22, "R3 seq green");
        do_read(8'h33, "R3 seq blue");
        do_read(8'h11, "R3 seq wrap red");

        do_write(8'h03);
        do_read(8'h76, "R4 id");
        do_read(8'h11, "R4 after id red");
        do_read(8'h22, "R5 green");
        do_read(8'h33, "R5 blue");
        do_read(8'h11, "R5 red not id");
        do_read(8'h22, "R5 green again");

        do_write(8'h04);
        do_read(8'h44, "R2 acc red");
        do_read(8'h44, "R6 acc red held");
        do_write(8'h05);
        do_read(8'h55, "R2 acc green");
        do_read(8'h55, "R6 acc green held");
        do_write(8'h06);
        do_read(8'h66, "R2 acc blue");
        do_read(8'h66, "R6 acc blue held");
        do_write(8'h07);
        do_read(8'h7A, "R2 analog");
        ana_stat = 8'h5C;
        do_read(8'h5C, "R6 analog held");

        do_write(8'h00);
        do_read(8'h11, "R7 long read red", 5);
        do_read(8'h22, "R7 one step green");

        do_write(8'hFA);
        do_read(8'h33, "R8 upper bits ignored blue");

        pal_r = 8'hA1;
        pal_g = 8'hB2;
        pal_b = 8'hC3;
        repeat (4) @(negedge clk);
        check("R9 hold rd_data", rd_data, 8'h33);

        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h02;
        rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        @(negedge clk);
        check("R8 write wins rd_data", rd_data, 8'h33);
        do_read(8'hC3, "R8 write wins blue");
        do_read(8'hA1, "R3 wrap new red");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule